// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command pins, bank select, address bus and clock-enable of a DDR SDRAM through the mandatory start-up sequence. After reset it holds the clock-enable low for a long stabilization interval. It then raises the clock-enable, gives one idle cycle and issues a fixed series of commands: precharge-all, an extended mode load that enables the DLL, a base mode load with DLL reset, a second precharge-all, two auto-refreshes, and a final base mode load with DLL reset cleared. Every command is followed by a minimum number of idle (NOP) cycles. That number comes from one of three timing classes: row precharge, mode-register set, or refresh cycle.

When the last wait ends, `init_done` rises, and the sequencer keeps the bus idle until a downstream controller takes over. A separate lockout counter starts at the DLL-reset load. Its `read_ok` output tells the controller when the DLL has had enough cycles for READ commands to be legal. Burst length, CAS latency and drive strength are static inputs. The timing values are parameters. `rst_n` is asserted asynchronously and must be released synchronously to `clk`.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, `dram_cke` is 0, the command is NOP, and both `init_done` and `read_ok` are 0.
- R2: After reset release, `dram_cke` stays 0 for exactly PWRUP_CYC cycles, and the command stays NOP throughout that time.
- R3: `dram_cke` then goes to 1 and stays 1. Exactly one NOP cycle follows, and then PRECHARGE ALL: {cs_n,ras_n,cas_n,we_n}=0010 with address bit 10 set, all other address bits 0, and bank 0.
- R4: The commands appear in this order: PRECHARGE ALL, extended load, base load with DLL reset, PRECHARGE ALL, AUTO REFRESH (0001), AUTO REFRESH, base load without DLL reset. A mode load is encoded 0000.
- R5: Each command is followed by idle cycles before the next one: exactly T_RP NOP cycles after a precharge, T_MRD after a mode load, and T_RFC after a refresh.
- R6: The extended load drives bank 01, address bit 0 = 0 (DLL enabled), and address bit 1 = `cfg_reduced_drive`. All other address bits are 0.
- R7: Both base loads drive bank 00, the burst-length code on address[2:0], 0 on address[3], and the CAS-latency code on address[6:4]. Address bit 8 is 1 in the first base load and 0 in the second. All other address bits are 0.
- R8: `init_done` rises in the cycle after the last NOP of the final T_MRD wait. From then on it stays 1 and the command stays NOP.
- R9: If the DLL-reset load is on the bus in cycle c, `read_ok` is 0 before cycle c+DLL_LOCK and 1 from cycle c+DLL_LOCK onward.
- R10: A reset asserted partway through the sequence restarts it from the clock-enable-low wait, using the configuration present at release.
- R11: Whenever the command is NOP, the bank and address outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cfg_burst_len | input | 3 | Burst-length code for the base mode load |
| cfg_cas_lat | input | 3 | CAS-latency code for the base mode load |
| cfg_reduced_drive | input | 1 | 1 selects reduced output drive |
| dram_cke | output | 1 | Clock enable to the memory |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BA_W | Bank select |
| dram_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |
| read_ok | output | 1 | DLL lock interval elapsed; READ is legal |

## Verification
The assertions check these properties on every cycle:
- the bus is idle while the clock-enable is low, and the clock-enable never falls once raised;
- the clock-enable rises only after exactly the power-up count;
- every real command is followed by a NOP, and idle cycles carry zero bank and address;
- the DLL stays enabled in the extended load;
- the done flag and the read permission, once set, stay set, and the read permission rises exactly at the lockout distance from the DLL-reset load.

Only the bench's cycle-by-cycle comparison against its own expected stream can show the full command order, the exact gap lengths for each timing class, the mode-field contents for two different configurations, and a clean restart after a reset taken partway through the sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_ARM,
    ST_PRE_A,
    ST_LOAD_EXT,
    ST_LOAD_RST,
    ST_PRE_B,
    ST_REF_A,
    ST_REF_B,
    ST_LOAD_RUN,
    ST_READY
  } init_state_e;

  typedef enum logic [2:0] {
    CK_NOP,
    CK_PRE_ALL,
    CK_LOAD_EXT,
    CK_LOAD_BASE,
    CK_REFRESH
  } cmd_kind_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PRE     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_LOAD    = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam cmd_pins_t PINS_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  localparam int unsigned ALL_BANKS_BIT = 10;
  localparam int unsigned DLL_RST_BIT   = 8;
  localparam int unsigned DRIVE_BIT     = 1;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Count down to zero; a load takes precedence.
  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr_init_rdlock.sv
module ddr_init_rdlock #(
  parameter int unsigned LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic open
);

  localparam int unsigned LOCK_C = (LOCK_CYC == 0) ? 1 : LOCK_CYC;
  localparam int unsigned LW     = $clog2(LOCK_C + 1);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_d;
  logic          armed_q;
  logic          armed_d;
  logic          cnt_en;

  assign cnt_en = start | (armed_q & (cnt_q != LW'(LOCK_C)));

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (start) begin
      cnt_d   = LW'(1);
      armed_d = 1'b1;
    end else if (armed_q && (cnt_q != LW'(LOCK_C))) begin
      cnt_d = cnt_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign open = armed_q & (cnt_q == LW'(LOCK_C));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  cmd_kind_e         kind,
  input  logic              dll_rst,
  input  logic [2:0]        burst_len,
  input  logic [2:0]        cas_lat,
  input  logic              reduced_drive,
  output cmd_pins_t         pins,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    pins = PINS_NOP;
    ba   = '0;
    addr = '0;
    case (kind)
      CK_PRE_ALL: begin
        pins                = PINS_PRE;
        addr[ALL_BANKS_BIT] = 1'b1;
      end
      CK_LOAD_EXT: begin
        pins            = PINS_LOAD;
        ba              = BA_W'(1);
        addr[DRIVE_BIT] = reduced_drive;
      end
      CK_LOAD_BASE: begin
        pins              = PINS_LOAD;
        addr[2:0]         = burst_len;
        addr[6:4]         = cas_lat;
        addr[DLL_RST_BIT] = dll_rst;
      end
      CK_REFRESH: begin
        pins = PINS_REFRESH;
      end
      default: begin
        pins = PINS_NOP;
      end
    endcase
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned PWRUP_CYC = 40000,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_RFC     = 14,
  parameter int unsigned DLL_LOCK  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_reduced_drive,
  output logic              dram_cke,
  output logic              dram_cs_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BA_W-1:0]   dram_ba,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              init_done,
  output logic              read_ok
);

  // Every wait is at least one idle cycle.
  localparam int unsigned PWR_C = (PWRUP_CYC == 0) ? 1 : PWRUP_CYC;
  localparam int unsigned RP_C  = (T_RP  == 0) ? 1 : T_RP;
  localparam int unsigned MRD_C = (T_MRD == 0) ? 1 : T_MRD;
  localparam int unsigned RFC_C = (T_RFC == 0) ? 1 : T_RFC;
  localparam int unsigned MAX_A = (RP_C  > MRD_C) ? RP_C  : MRD_C;
  localparam int unsigned MAX_B = (RFC_C > MAX_A) ? RFC_C : MAX_A;
  localparam int unsigned MAX_W = (PWR_C > MAX_B) ? PWR_C : MAX_B;
  localparam int unsigned TMR_W = $clog2(MAX_W + 1);

  init_state_e      state_q, state_d;
  logic             wait_q,  wait_d;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_last;
  init_state_e      step_next;
  logic [TMR_W-1:0] step_wait;
  cmd_kind_e        kind;
  logic             base_dll_rst;
  logic             dll_rst_issue;
  cmd_pins_t        pins;

  // Successor and idle length for each command step.
  always_comb begin
    step_next = ST_READY;
    step_wait = TMR_W'(MRD_C);
    case (state_q)
      ST_PRE_A:    begin step_next = ST_LOAD_EXT; step_wait = TMR_W'(RP_C);  end
      ST_LOAD_EXT: begin step_next = ST_LOAD_RST; step_wait = TMR_W'(MRD_C); end
      ST_LOAD_RST: begin step_next = ST_PRE_B;    step_wait = TMR_W'(MRD_C); end
      ST_PRE_B:    begin step_next = ST_REF_A;    step_wait = TMR_W'(RP_C);  end
      ST_REF_A:    begin step_next = ST_REF_B;    step_wait = TMR_W'(RFC_C); end
      ST_REF_B:    begin step_next = ST_LOAD_RUN; step_wait = TMR_W'(RFC_C); end
      ST_LOAD_RUN: begin step_next = ST_READY;    step_wait = TMR_W'(MRD_C); end
      default:     begin step_next = ST_READY;    step_wait = TMR_W'(MRD_C); end
    endcase
  end

  // Next-state logic: each command step has an issue cycle and a wait phase.
  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_PWRUP: begin
        if (tmr_last) begin
          state_d = ST_ARM;
          wait_d  = 1'b0;
        end
      end
      ST_ARM: begin
        state_d = ST_PRE_A;
        wait_d  = 1'b0;
      end
      ST_READY: begin
        state_d = ST_READY;
      end
      default: begin
        if (!wait_q) begin
          wait_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = step_wait;
        end else if (tmr_last) begin
          state_d = step_next;
          wait_d  = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      wait_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
    end
  end

  ddr_init_timer #(
    .CNT_W   (TMR_W),
    .RST_VAL (PWR_C)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  // Command selection: real commands only in the issue cycle.
  always_comb begin
    kind         = CK_NOP;
    base_dll_rst = 1'b0;
    if (!wait_q) begin
      case (state_q)
        ST_PRE_A, ST_PRE_B: kind = CK_PRE_ALL;
        ST_LOAD_EXT:        kind = CK_LOAD_EXT;
        ST_LOAD_RST: begin
          kind         = CK_LOAD_BASE;
          base_dll_rst = 1'b1;
        end
        ST_REF_A, ST_REF_B: kind = CK_REFRESH;
        ST_LOAD_RUN:        kind = CK_LOAD_BASE;
        default:            kind = CK_NOP;
      endcase
    end
  end

  assign dll_rst_issue = (state_q == ST_LOAD_RST) && !wait_q;

  ddr_init_cmd_enc #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_enc (
    .kind          (kind),
    .dll_rst       (base_dll_rst),
    .burst_len     (cfg_burst_len),
    .cas_lat       (cfg_cas_lat),
    .reduced_drive (cfg_reduced_drive),
    .pins          (pins),
    .ba            (dram_ba),
    .addr          (dram_addr)
  );

  ddr_init_rdlock #(
    .LOCK_CYC (DLL_LOCK)
  ) u_rdlock (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dll_rst_issue),
    .open  (read_ok)
  );

  assign dram_cke   = (state_q != ST_PWRUP);
  assign dram_cs_n  = pins.cs_n;
  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;
  assign init_done  = (state_q == ST_READY);

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned PWRUP_CYC = 40000,
  parameter int unsigned DLL_LOCK  = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dram_cke,
  input logic              dram_cs_n,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic [BA_W-1:0]   dram_ba,
  input logic [ADDR_W-1:0] dram_addr,
  input logic              init_done,
  input logic              read_ok
);

  localparam int unsigned LOW_W = $clog2(PWRUP_CYC + 2);
  localparam int unsigned SNC_W = $clog2(DLL_LOCK + 2);

  logic [3:0]       cmd;
  logic             is_nop;
  logic             dll_load;
  logic [LOW_W-1:0] low_cnt;
  logic [SNC_W-1:0] since_cnt;
  logic             seen_dll;

  assign cmd      = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
  assign is_nop   = (cmd == 4'b0111);
  assign dll_load = (cmd == 4'b0000) && (dram_ba == '0) && dram_addr[8];

  // Cycles with the clock-enable low since reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!dram_cke && (low_cnt != LOW_W'(PWRUP_CYC + 1))) begin
      low_cnt <= low_cnt + LOW_W'(1);
    end
  end

  // Cycles since the DLL-reset mode load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_cnt <= '0;
      seen_dll  <= 1'b0;
    end else if (dll_load) begin
      since_cnt <= SNC_W'(1);
      seen_dll  <= 1'b1;
    end else if (seen_dll && (since_cnt != SNC_W'(DLL_LOCK + 1))) begin
      since_cnt <= since_cnt + SNC_W'(1);
    end
  end

  p_nop_while_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cke |-> is_nop);

  p_cke_rise_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cke) |-> (low_cnt == LOW_W'(PWRUP_CYC)));

  p_cke_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cke |=> dram_cke);

  p_cmd_then_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  p_dll_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == 4'b0000) && (dram_ba == BA_W'(1))) |-> !dram_addr[0]);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);

  p_read_ok_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |=> read_ok);

  p_read_ok_distance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_ok) |-> (seen_dll && (since_cnt == SNC_W'(DLL_LOCK))));

  p_idle_bus_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> ((dram_addr == '0) && (dram_ba == '0)));

endmodule

bind ddr_init_seq ddr_init_chk #(
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .PWRUP_CYC (PWRUP_CYC),
  .DLL_LOCK  (DLL_LOCK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dram_cke   (dram_cke),
  .dram_cs_n  (dram_cs_n),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_ba    (dram_ba),
  .dram_addr  (dram_addr),
  .init_done  (init_done),
  .read_ok    (read_ok)
);

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int PWRUP  = 50;
  localparam int TRP    = 3;
  localparam int TMRD   = 2;
  localparam int TRFC   = 7;
  localparam int LOCK   = 40;

  localparam bit [3:0] C_NOP = 4'b0111;
  localparam bit [3:0] C_PRE = 4'b0010;
  localparam bit [3:0] C_LMR = 4'b0000;
  localparam bit [3:0] C_REF = 4'b0001;

  logic              clk;
  logic              rst_n;
  logic [2:0]        cfg_burst_len;
  logic [2:0]        cfg_cas_lat;
  logic              cfg_reduced_drive;
  logic              dram_cke;
  logic              dram_cs_n;
  logic              dram_ras_n;
  logic              dram_cas_n;
  logic              dram_we_n;
  logic [BA_W-1:0]   dram_ba;
  logic [ADDR_W-1:0] dram_addr;
  logic              init_done;
  logic              read_ok;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .PWRUP_CYC (PWRUP),
    .T_RP      (TRP),
    .T_MRD     (TMRD),
    .T_RFC     (TRFC),
    .DLL_LOCK  (LOCK)
  ) i_ddr_init_seq (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_burst_len     (cfg_burst_len),
    .cfg_cas_lat       (cfg_cas_lat),
    .cfg_reduced_drive (cfg_reduced_drive),
    .dram_cke          (dram_cke),
    .dram_cs_n         (dram_cs_n),
    .dram_ras_n        (dram_ras_n),
    .dram_cas_n        (dram_cas_n),
    .dram_we_n         (dram_we_n),
    .dram_ba           (dram_ba),
    .dram_addr         (dram_addr),
    .init_done         (init_done),
    .read_ok           (read_ok)
  );

  typedef struct {
    bit              cke;
    bit [3:0]        cmd;
    bit [BA_W-1:0]   ba;
    bit [ADDR_W-1:0] addr;
    bit              done;
    string           req;
  } exp_t;

  exp_t q[$];
  int   dll_idx;
  int   n_chk;
  int   n_fail;
  bit   finished;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void push(input bit cke, input bit [3:0] cmd, input bit [BA_W-1:0] ba,
                               input bit [ADDR_W-1:0] addr, input bit done, input string req);
    exp_t e;
    e.cke = cke; e.cmd = cmd; e.ba = ba; e.addr = addr; e.done = done; e.req = req;
    q.push_back(e);
  endfunction

  function automatic void idle(input int n);
    for (int i = 0; i < n; i++) push(1'b1, C_NOP, '0, '0, 1'b0, "R5 R11");
  endfunction

  function automatic bit [ADDR_W-1:0] base_word(input bit [2:0] bl, input bit [2:0] cl, input bit dll);
    bit [ADDR_W-1:0] a;
    a = '0;
    a[2:0] = bl;
    a[6:4] = cl;
    a[8]   = dll;
    return a;
  endfunction

  // Expected bus stream, one entry per cycle from reset release.
  function automatic void build(input bit [2:0] bl, input bit [2:0] cl, input bit drv, input int tail);
    bit [ADDR_W-1:0] a;
    q.delete();
    for (int i = 0; i < PWRUP; i++) push(1'b0, C_NOP, '0, '0, 1'b0, "R2");
    push(1'b1, C_NOP, '0, '0, 1'b0, "R3");
    a = '0; a[10] = 1'b1;
    push(1'b1, C_PRE, '0, a, 1'b0, "R3 R4");
    idle(TRP);
    a = '0; a[1] = drv;
    push(1'b1, C_LMR, 2'b01, a, 1'b0, "R4 R6");
    idle(TMRD);
    dll_idx = q.size();
    push(1'b1, C_LMR, 2'b00, base_word(bl, cl, 1'b1), 1'b0, "R4 R7");
    idle(TMRD);
    a = '0; a[10] = 1'b1;
    push(1'b1, C_PRE, '0, a, 1'b0, "R4");
    idle(TRP);
    push(1'b1, C_REF, '0, '0, 1'b0, "R4");
    idle(TRFC);
    push(1'b1, C_REF, '0, '0, 1'b0, "R4");
    idle(TRFC);
    push(1'b1, C_LMR, 2'b00, base_word(bl, cl, 1'b0), 1'b0, "R4 R7");
    idle(TMRD);
    for (int i = 0; i < tail; i++) push(1'b1, C_NOP, '0, '0, 1'b1, "R8");
  endfunction

  // Compare the first n entries, one per cycle, starting at a falling edge.
  task automatic run(input int n, input string tag);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      e = q[i];
      chk({tag, e.req}, "cke",  dram_cke, e.cke);
      chk({tag, e.req}, "cmd",  {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, e.cmd);
      chk({tag, e.req}, "ba",   dram_ba, e.ba);
      chk({tag, e.req}, "addr", dram_addr, e.addr);
      chk({tag, e.req}, "done", init_done, e.done);
      chk({tag, "R9"},  "read_ok", read_ok, (i >= dll_idx + LOCK) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk({tag, "R1"}, "cke",     dram_cke, 0);
    chk({tag, "R1"}, "cmd",     {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, C_NOP);
    chk({tag, "R1"}, "done",    init_done, 0);
    chk({tag, "R1"}, "read_ok", read_ok, 0);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0; dll_idx = 0;
    rst_n = 1'b0;
    cfg_burst_len = 3'b010; cfg_cas_lat = 3'b010; cfg_reduced_drive = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("");
    // Full sequence, normal drive.
    build(3'b010, 3'b010, 1'b0, 60);
    rst_n = 1'b1;
    run(q.size(), "");
    // Reset partway through a second sequence (R10).
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(70, "R10 ");
    #1 rst_n = 1'b0;
    cfg_burst_len = 3'b011; cfg_cas_lat = 3'b110; cfg_reduced_drive = 1'b1;
    @(negedge clk);
    check_reset_state("R10 ");
    repeat (2) @(negedge clk);
    build(3'b011, 3'b110, 1'b1, 60);
    rst_n = 1'b1;
    run(q.size(), "R10 ");
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule